// File: doc/BRIEF.md
# Banked Special Register File

This block holds the processor's small set of special control registers and serves the move-to and move-from instructions that reach them. Each access carries a register number, a read or write flag, a data word, and the core's current context: handler or thread mode, privilege, and security state. The priority-mask bit, fault-mask bit, base priority and control register are each kept twice, one copy per security state. Every access uses the copy that belongs to the current state.

The main and process stack pointers are not stored here. The core presents the active and the inactive pointer, and this block decides which one a read returns. A write to a pointer goes back out as a write strobe to the active or the inactive pointer. When a control write changes the stack-select bit, the block raises a swap request and leaves the swap itself to the core. A separate port carries exception-exit events, which clear the fault mask automatically. The current-state copies of the mask and control fields are also driven out continuously, for the priority logic to use.

Top module: `sysreg_bank`

## Requirements
- R1: After reset every stored field is zero in both banks. The registered outputs `rd_data`, `rd_err`, `swap_req`, `swap_sel`, `sp_wr`, `sp_wr_inactive` and `sp_wr_data` are all zero.
- R2: The register numbers are 8 (main SP), 9 (process SP), 16 (priority mask), 17 (base priority), 18 (base-priority raise-only alias), 19 (fault mask) and 20 (control). A read places its value on `rd_data` in the cycle after the access. The value is zero-extended. Control reads back with stack-select in bit 1 and the unprivileged flag in bit 0. Reads of 17 and 18 both return base priority. A write access returns zero on `rd_data`.
- R3: Let S be the stack-select bit of the current bank. Reading 8 returns `sp_inactive_i` when S is 1 and `sp_active_i` when S is 0. Reading 9 returns the other pointer. A privileged write to 8 or 9 pulses `sp_wr` one cycle later with `sp_wr_data` equal to the written word. `sp_wr_inactive` follows the same mapping: for 8 it equals S, for 9 it equals not S.
- R4: Writes to the priority mask and the fault mask keep only bit 0 of the data. A write to base priority keeps bits [PRIO_W-1:0].
- R5: A write to 18 changes base priority only when the new value is nonzero and either is below the current value or the current value is zero. Otherwise base priority keeps its value.
- R6: A privileged control write always sets the unprivileged flag from data bit 0. In thread mode, if data bit 1 differs from S, S takes the new value and `swap_req` pulses one cycle later with `swap_sel` equal to the new value. In handler mode, S and `swap_req` are left unchanged.
- R7: With SECURITY_EXT=1, every read and write uses the bank chosen by `secure_state` (0 = non-secure, 1 = secure). The other bank is left untouched. The `eff_*` outputs show the chosen bank.
- R8: An exception exit whose `exc_is_nmi` is 0 clears a fault mask. With SECURITY_EXT=1 it clears the bank named by `exc_ret_state`, and only when `exc_prio_ok` is 1. With SECURITY_EXT=0 it always clears the single bank. The clear overrides a fault-mask write made in the same cycle. An NMI exit clears nothing.
- R9: An access to any other register number returns zero, changes nothing, and pulses `rd_err` one cycle later.
- R10: An unprivileged write changes no register and raises no `swap_req` or `sp_wr`. An unprivileged read of any register other than control returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_regnum | input | 5 | Register number |
| acc_wdata | input | DATA_W | Write data |
| handler_mode | input | 1 | Core is in handler mode |
| privileged | input | 1 | Access is privileged |
| secure_state | input | 1 | Current security state |
| sp_active_i | input | DATA_W | Stack pointer in use now |
| sp_inactive_i | input | DATA_W | Stack pointer not in use now |
| exc_exit | input | 1 | Exception-exit event |
| exc_is_nmi | input | 1 | The exiting exception is NMI |
| exc_ret_state | input | 1 | Security-state bit of the return value |
| exc_prio_ok | input | 1 | Raw execution priority is at least 0 |
| rd_data | output | DATA_W | Read data, one cycle after the access |
| rd_err | output | 1 | Unknown-register pulse |
| swap_req | output | 1 | Stack swap request pulse |
| swap_sel | output | 1 | Stack-select value requested by the swap |
| sp_wr | output | 1 | Stack pointer write strobe |
| sp_wr_inactive | output | 1 | 1 = write the inactive pointer, 0 = write the active one |
| sp_wr_data | output | DATA_W | Stack pointer write data |
| eff_primask | output | 1 | Priority mask of the current bank |
| eff_faultmask | output | 1 | Fault mask of the current bank |
| eff_basepri | output | PRIO_W | Base priority of the current bank |
| eff_npriv | output | 1 | Unprivileged flag of the current bank |
| eff_spsel | output | 1 | Stack-select bit of the current bank |

## Verification
The bench builds the block with SECURITY_EXT=1, PRIO_W=8 and DATA_W=32. Both banks therefore exist, so the bench can check that a write made in one state is invisible from the other. It can also steer the exit clear into the bank that is not current. An 8-bit base priority lets random data reach zero, reach values on both sides of the stored one, and set upper bits that R4 must discard. The single-bank variant (SECURITY_EXT=0) is only elaborated, not run.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [4:0] {
        SR_MSP   = 5'd8,
        SR_PSP   = 5'd9,
        SR_PMASK = 5'd16,
        SR_BPRI  = 5'd17,
        SR_BPMAX = 5'd18,
        SR_FMASK = 5'd19,
        SR_CTRL  = 5'd20
    } sreg_num_e;

    typedef struct packed {
        logic msp;
        logic psp;
        logic pmask;
        logic bpri;
        logic bpmax;
        logic fmask;
        logic ctrl;
    } sreg_sel_t;

    localparam int CTRL_NPRIV_BIT = 0;
    localparam int CTRL_SPSEL_BIT = 1;

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
    import sreg_pkg::*;
(
    input  logic [4:0] regnum,
    output sreg_sel_t  sel,
    output logic       known
);
    always_comb begin
        sel       = '0;
        sel.msp   = (regnum == SR_MSP);
        sel.psp   = (regnum == SR_PSP);
        sel.pmask = (regnum == SR_PMASK);
        sel.bpri  = (regnum == SR_BPRI);
        sel.bpmax = (regnum == SR_BPMAX);
        sel.fmask = (regnum == SR_FMASK);
        sel.ctrl  = (regnum == SR_CTRL);
        known     = |sel;
    end
endmodule

// File: rtl/sreg_raise.sv
module sreg_raise #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] cand,
    output logic         take
);
    always_comb begin
        take = (cand != '0) && ((cur == '0) || (cand < cur));
    end
endmodule

// File: rtl/sreg_exit_clear.sv
module sreg_exit_clear #(
    parameter bit SECURITY_EXT = 1'b1
) (
    input  logic       exit_ev,
    input  logic       is_nmi,
    input  logic       prio_ok,
    input  logic       ret_state,
    output logic [1:0] clr
);
    generate
        if (SECURITY_EXT) begin : g_banked
            always_comb begin
                clr = '0;
                if (exit_ev && !is_nmi && prio_ok) begin
                    clr[ret_state] = 1'b1;
                end
            end
        end else begin : g_single
            always_comb begin
                clr    = '0;
                clr[0] = exit_ev && !is_nmi;
            end
        end
    endgenerate
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sreg_pkg::*;
#(
    parameter bit SECURITY_EXT = 1'b1,
    parameter int DATA_W       = 32,
    parameter int PRIO_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [4:0]        acc_regnum,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              handler_mode,
    input  logic              privileged,
    input  logic              secure_state,
    input  logic [DATA_W-1:0] sp_active_i,
    input  logic [DATA_W-1:0] sp_inactive_i,
    input  logic              exc_exit,
    input  logic              exc_is_nmi,
    input  logic              exc_ret_state,
    input  logic              exc_prio_ok,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              swap_req,
    output logic              swap_sel,
    output logic              sp_wr,
    output logic              sp_wr_inactive,
    output logic [DATA_W-1:0] sp_wr_data,
    output logic              eff_primask,
    output logic              eff_faultmask,
    output logic [PRIO_W-1:0] eff_basepri,
    output logic              eff_npriv,
    output logic              eff_spsel
);
    localparam int NBANK = 2;

    typedef struct packed {
        logic [NBANK-1:0]             pmask;
        logic [NBANK-1:0]             fmask;
        logic [NBANK-1:0][PRIO_W-1:0] bpri;
        logic [NBANK-1:0]             npriv;
        logic [NBANK-1:0]             spsel;
        logic [DATA_W-1:0]            rd;
        logic                         err;
        logic                         swp;
        logic                         swp_sel;
        logic                         spw;
        logic                         spw_inact;
        logic [DATA_W-1:0]            spw_data;
    } state_t;

    state_t     st_d, st_q;
    sreg_sel_t  sel;
    logic       known;
    logic       bidx;
    logic       raise_ok;
    logic [1:0] fm_clr;
    logic [DATA_W-1:0] rd_val;

    assign bidx = SECURITY_EXT ? secure_state : 1'b0;

    sreg_decode u_dec (
        .regnum (acc_regnum),
        .sel    (sel),
        .known  (known)
    );

    sreg_raise #(.W(PRIO_W)) u_raise (
        .cur  (st_q.bpri[bidx]),
        .cand (acc_wdata[PRIO_W-1:0]),
        .take (raise_ok)
    );

    sreg_exit_clear #(.SECURITY_EXT(SECURITY_EXT)) u_exit (
        .exit_ev   (exc_exit),
        .is_nmi    (exc_is_nmi),
        .prio_ok   (exc_prio_ok),
        .ret_state (exc_ret_state),
        .clr       (fm_clr)
    );

    // Read mux over the current bank
    always_comb begin
        rd_val = '0;
        unique case (1'b1)
            sel.msp:            rd_val = st_q.spsel[bidx] ? sp_inactive_i : sp_active_i;
            sel.psp:            rd_val = st_q.spsel[bidx] ? sp_active_i : sp_inactive_i;
            sel.pmask:          rd_val = {{(DATA_W-1){1'b0}}, st_q.pmask[bidx]};
            sel.bpri, sel.bpmax: rd_val = {{(DATA_W-PRIO_W){1'b0}}, st_q.bpri[bidx]};
            sel.fmask:          rd_val = {{(DATA_W-1){1'b0}}, st_q.fmask[bidx]};
            sel.ctrl:           rd_val = {{(DATA_W-2){1'b0}}, st_q.spsel[bidx], st_q.npriv[bidx]};
            default:            rd_val = '0;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.rd        = '0;
        st_d.err       = 1'b0;
        st_d.swp       = 1'b0;
        st_d.swp_sel   = 1'b0;
        st_d.spw       = 1'b0;
        st_d.spw_inact = 1'b0;
        st_d.spw_data  = '0;

        if (acc_valid) begin
            st_d.err = !known;
            if (!acc_write) begin
                if (known && (privileged || sel.ctrl)) begin
                    st_d.rd = rd_val;
                end
            end else if (known && privileged) begin
                if (sel.pmask) st_d.pmask[bidx] = acc_wdata[0];
                if (sel.fmask) st_d.fmask[bidx] = acc_wdata[0];
                if (sel.bpri)  st_d.bpri[bidx]  = acc_wdata[PRIO_W-1:0];
                if (sel.bpmax && raise_ok) st_d.bpri[bidx] = acc_wdata[PRIO_W-1:0];
                if (sel.ctrl) begin
                    st_d.npriv[bidx] = acc_wdata[CTRL_NPRIV_BIT];
                    if (!handler_mode && (acc_wdata[CTRL_SPSEL_BIT] != st_q.spsel[bidx])) begin
                        st_d.spsel[bidx] = acc_wdata[CTRL_SPSEL_BIT];
                        st_d.swp         = 1'b1;
                        st_d.swp_sel     = acc_wdata[CTRL_SPSEL_BIT];
                    end
                end
                if (sel.msp || sel.psp) begin
                    st_d.spw       = 1'b1;
                    st_d.spw_inact = sel.msp ? st_q.spsel[bidx] : !st_q.spsel[bidx];
                    st_d.spw_data  = acc_wdata;
                end
            end
        end

        // exception-exit clear wins over a same-cycle write
        st_d.fmask = st_d.fmask & ~fm_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data        = st_q.rd;
    assign rd_err         = st_q.err;
    assign swap_req       = st_q.swp;
    assign swap_sel       = st_q.swp_sel;
    assign sp_wr          = st_q.spw;
    assign sp_wr_inactive = st_q.spw_inact;
    assign sp_wr_data     = st_q.spw_data;
    assign eff_primask    = st_q.pmask[bidx];
    assign eff_faultmask  = st_q.fmask[bidx];
    assign eff_basepri    = st_q.bpri[bidx];
    assign eff_npriv      = st_q.npriv[bidx];
    assign eff_spsel      = st_q.spsel[bidx];
endmodule

// File: rtl/sreg_bank_chk.sv
module sreg_bank_chk #(
    parameter bit SECURITY_EXT = 1'b1,
    parameter int DATA_W       = 32,
    parameter int PRIO_W       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [4:0]        acc_regnum,
    input logic              handler_mode,
    input logic              privileged,
    input logic              secure_state,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              exc_exit,
    input logic              exc_is_nmi,
    input logic              exc_ret_state,
    input logic              exc_prio_ok,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_err,
    input logic              swap_req,
    input logic              eff_primask,
    input logic              eff_faultmask,
    input logic [PRIO_W-1:0] eff_basepri,
    input logic              eff_npriv
);
    logic reg_known;
    assign reg_known = (acc_regnum == 5'd8) || (acc_regnum == 5'd9) ||
                       ((acc_regnum >= 5'd16) && (acc_regnum <= 5'd20));

    a_r9_unknown_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !reg_known) |=> rd_err);

    a_r9_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == '0));

    a_r5_zero_max_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && privileged && acc_regnum == 5'd18 &&
         acc_wdata[PRIO_W-1:0] == '0)
        |=> (secure_state != $past(secure_state)) || $stable(eff_basepri));

    a_r6_swap_from_thread_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req |-> $past(acc_valid && acc_write && privileged &&
                           !handler_mode && acc_regnum == 5'd20));

    a_r10_unpriv_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !privileged && !exc_exit)
        |=> (secure_state != $past(secure_state)) ||
            ($stable(eff_primask) && $stable(eff_faultmask) &&
             $stable(eff_basepri) && $stable(eff_npriv) && !swap_req));

    a_r8_exit_clears_fmask: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_exit && !exc_is_nmi &&
         (!SECURITY_EXT || (exc_prio_ok && exc_ret_state == secure_state)))
        |=> (SECURITY_EXT && secure_state != $past(secure_state)) || !eff_faultmask);
endmodule

bind sysreg_bank sreg_bank_chk #(
    .SECURITY_EXT(SECURITY_EXT),
    .DATA_W(DATA_W),
    .PRIO_W(PRIO_W)
) u_chk (.*);

// File: tb/sysreg_bank_tb_top.sv
module sysreg_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 0, acc_write = 0, handler_mode = 0, privileged = 0, secure_state = 0;
    logic [4:0] acc_regnum = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic [DW-1:0] sp_active_i = 32'h2000_1000, sp_inactive_i = 32'h2000_8000;
    logic exc_exit = 0, exc_is_nmi = 0, exc_ret_state = 0, exc_prio_ok = 0;
    logic [DW-1:0] rd_data, sp_wr_data;
    logic rd_err, swap_req, swap_sel, sp_wr, sp_wr_inactive;
    logic eff_primask, eff_faultmask, eff_npriv, eff_spsel;
    logic [PW-1:0] eff_basepri;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model, one entry per bank
    logic [1:0] m_pm, m_fm, m_np, m_ss;
    logic [PW-1:0] m_bp [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    sysreg_bank #(.SECURITY_EXT(1'b1), .DATA_W(DW), .PRIO_W(PW)) dut_i (.*);

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit is_known(input logic [4:0] r);
        return r == 5'd8 || r == 5'd9 || (r >= 5'd16 && r <= 5'd20);
    endfunction

    function automatic logic [DW-1:0] model_read(input logic [4:0] r, input logic b, input logic pv);
        if (!is_known(r)) return '0;
        if (!pv && r != 5'd20) return '0;
        case (r)
            5'd8:  return m_ss[b] ? sp_inactive_i : sp_active_i;
            5'd9:  return m_ss[b] ? sp_active_i : sp_inactive_i;
            5'd16: return {31'b0, m_pm[b]};
            5'd17, 5'd18: return {24'b0, m_bp[b]};
            5'd19: return {31'b0, m_fm[b]};
            default: return {30'b0, m_ss[b], m_np[b]};
        endcase
    endfunction

    // one cycle: optional access and optional exit event, then full check
    task automatic step(input logic v, input logic w, input logic [4:0] r, input logic [DW-1:0] d,
                        input logic hm, input logic pv, input logic sec,
                        input logic ex, input logic nmi, input logic rs, input logic pok);
        logic [DW-1:0] e_rd;
        logic e_err, e_swp, e_ssel, e_spw, e_spi;
        logic [DW-1:0] e_spd;
        e_rd = '0; e_err = 0; e_swp = 0; e_ssel = 0; e_spw = 0; e_spi = 0; e_spd = '0;
        if (v) begin
            e_err = !is_known(r);
            if (!w) e_rd = model_read(r, sec, pv);
            else if (is_known(r) && pv) begin
                case (r)
                    5'd16: m_pm[sec] = d[0];
                    5'd19: m_fm[sec] = d[0];
                    5'd17: m_bp[sec] = d[PW-1:0];
                    5'd18: if (d[PW-1:0] != 0 && (m_bp[sec] == 0 || d[PW-1:0] < m_bp[sec]))
                               m_bp[sec] = d[PW-1:0];
                    5'd20: begin
                        m_np[sec] = d[0];
                        if (!hm && d[1] != m_ss[sec]) begin
                            e_swp = 1; e_ssel = d[1]; m_ss[sec] = d[1];
                        end
                    end
                    default: begin
                        e_spw = 1; e_spd = d;
                        e_spi = (r == 5'd8) ? m_ss[sec] : !m_ss[sec];
                    end
                endcase
            end
        end
        if (ex && !nmi && pok) m_fm[rs] = 1'b0;
        acc_valid = v; acc_write = w; acc_regnum = r; acc_wdata = d;
        handler_mode = hm; privileged = pv; secure_state = sec;
        exc_exit = ex; exc_is_nmi = nmi; exc_ret_state = rs; exc_prio_ok = pok;
        @(posedge clk);
        @(negedge clk);
        chk(rd_data, e_rd, "R2/R3/R10 rd_data");
        chk({31'b0, rd_err}, {31'b0, e_err}, "R9 rd_err");
        chk({30'b0, swap_req, swap_sel}, {30'b0, e_swp, e_ssel}, "R6 swap");
        chk({31'b0, sp_wr}, {31'b0, e_spw}, "R3 sp_wr");
        chk({31'b0, sp_wr_inactive}, {31'b0, e_spi}, "R3 sp_wr_inactive");
        chk(sp_wr_data, e_spd, "R3 sp_wr_data");
        chk({24'b0, eff_basepri}, {24'b0, m_bp[sec]}, "R4/R5/R7 basepri");
        chk({28'b0, eff_primask, eff_faultmask, eff_npriv, eff_spsel},
            {28'b0, m_pm[sec], m_fm[sec], m_np[sec], m_ss[sec]}, "R4/R6/R7/R8 masks");
        acc_valid = 0; exc_exit = 0;
    endtask

    task automatic wr(input logic [4:0] r, input logic [DW-1:0] d, input logic sec);
        step(1, 1, r, d, 0, 1, sec, 0, 0, 0, 0);
    endtask
    task automatic rd(input logic [4:0] r, input logic sec);
        step(1, 0, r, '0, 0, 1, sec, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_pm = '0; m_fm = '0; m_np = '0; m_ss = '0; m_bp[0] = '0; m_bp[1] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(rd_data, '0, "R1 rd_data");
        chk({26'b0, rd_err, swap_req, swap_sel, sp_wr, sp_wr_inactive, eff_faultmask},
            '0, "R1 outputs");
        chk(sp_wr_data, '0, "R1 sp_wr_data");
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 16; r <= 20; r++) rd(5'(r), 1'b0);   // R1 reads zero
        // R4: only low bits stored
        wr(5'd16, 32'hFFFF_FFFE, 0);
        wr(5'd17, 32'hABCD_EF5A, 0);
        rd(5'd17, 0);
        // R5 raise-only alias corners
        wr(5'd17, 32'h0, 0);
        wr(5'd18, 32'h0, 0);        // zero value: no change
        wr(5'd18, 32'h5, 0);        // current zero: taken
        wr(5'd18, 32'h9, 0);        // higher: ignored
        wr(5'd18, 32'h3, 0);        // lower: taken
        rd(5'd18, 0);
        // R7: other bank untouched
        rd(5'd17, 1);
        wr(5'd19, 32'h1, 1);
        rd(5'd19, 0);
        // R6 control: thread swap, handler no swap
        wr(5'd20, 32'h3, 0);
        rd(5'd8, 0);                // R3 with select set
        rd(5'd9, 0);
        wr(5'd8, 32'h1234_5678, 0);
        step(1, 1, 5'd20, 32'h0, 1, 1, 0, 0, 0, 0, 0);
        // R10 unprivileged
        step(1, 1, 5'd16, 32'h1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 5'd17, '0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 5'd20, '0, 0, 0, 0, 0, 0, 0, 0);
        // R9 unknown numbers
        step(1, 0, 5'd21, '0, 0, 1, 0, 0, 0, 0, 0);
        step(1, 1, 5'd0, 32'hFF, 0, 1, 0, 0, 0, 0, 0);
        // R8 exit cases
        wr(5'd19, 32'h1, 0);
        step(0, 0, 0, '0, 0, 1, 0, 1, 1, 0, 1);       // NMI: no clear
        step(0, 0, 0, '0, 0, 1, 0, 1, 0, 0, 0);       // priority negative: no clear
        step(0, 0, 0, '0, 0, 1, 0, 1, 0, 1, 1);       // clears bank 1 only
        rd(5'd19, 1);
        step(1, 1, 5'd19, 32'h1, 0, 1, 0, 1, 0, 0, 1); // clear beats write
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] r;
            logic [DW-1:0] d;
            int k;
            k = $urandom_range(0, 9);
            r = (k < 2) ? 5'(8 + k) : (k < 7) ? 5'(14 + k) : 5'($urandom_range(0, 31));
            d = $urandom();
            if ($urandom_range(0, 3) == 0) d = d & 32'hF;
            step($urandom_range(0, 5) != 0, $urandom_range(0, 1), r, d,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 7) != 0, $urandom_range(0, 1),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 1), $urandom_range(0, 3) != 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
    end
endmodule